// File: doc/BRIEF.md
# Multi-CPU Master Interrupt Router

This block collects 32 level-sensitive interrupt source lines plus one timer line per CPU and decides which processor interrupt levels each CPU sees. It holds a master pending word, a master disable word and a target-CPU number. Sources that are pending and enabled are steered to the single target CPU. There they are turned into a 16-bit level vector through a fixed table that maps each source to a level, with one level per source.

Every CPU's level vector also merges the soft-interrupt levels kept outside the block, plus that CPU's own timer level. Software reaches the pending, disable and target state through a small word-addressed register bus. Separate enable and disable strobe words let one write touch any subset of sources. Bit 31 of the disable word switches off all master routing at once. The level vectors are registered, one per CPU, and go to the processors' interrupt inputs.

Top module: `irq_master_router`

## Requirements
- R1: After reset the pending word is 0, the target CPU is 0, the disable word holds 0x0FA2007F (the positions that can never be enabled), and every CPU level vector is 0.
- R2: Reads are combinational on the word address. Word 0 returns pending with bit 31 forced to 0. Word 1 returns disable ANDed with the valid mask ~0x0FA2007F. Word 4 returns the target in bits 3:0. Every other word returns 0.
- R3: A write to word 2 clears each disable bit whose data bit is 1 and which lies inside the valid mask. Disable bits outside the mask stay 1.
- R4: A write to word 3 sets each valid-mask disable bit named in the data and clears the same pending bits. This clear wins over a source or timer raise of that bit at the same clock edge.
- R5: A write to word 4 loads the target CPU from data bits 3:0.
- R6: A source line that rises sets its pending bit only if its disable bit was clear before that edge. A source line that falls clears its pending bit.
- R7: The timer lines act on pending bit TIMER_SRC (default 14). Any timer rise sets it whatever its disable bit holds, and any timer fall clears it. While CPU i's timer line is high, CPU i's vector has level bit map[TIMER_SRC] set (level 15 by default).
- R8: The master pending sources reach only the CPU whose index equals the target, and only when pending is nonzero and disable bit 31 is clear. Each pending source j sets level bit map[j]. The default map is map[j] = (j mod 15) + 1. A target of NCPU or higher reaches no CPU.
- R9: Bits 15:1 of CPU i's soft-level input are ORed into its vector. Bit 0 of that input is ignored, and bit 0 of every vector stays 0.
- R10: Each level vector is registered. It shows the inputs and register state present before the clock edge that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | 32 | Level-sensitive master interrupt sources |
| timer_lines | input | NCPU | Per-CPU timer interrupt lines |
| soft_levels | input | 16*NCPU | Per-CPU soft-interrupt levels, CPU i in bits 16i+15:16i |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_levels | output | 16*NCPU | Registered level vector per CPU |

## Verification
A disable-strobe write and a source raise on the same bit can land on one clock edge. The bench provokes this by holding a line low, then raising it in the very cycle that word 3 names that bit. It does the same with a timer raise against a disable of bit 14. In both cases it expects the pending bit to read back 0 and no level to appear on the target CPU in the following cycle. The bench's reference model runs in parallel and is compared on every cycle. It also catches the weaker case, where an enable write meets a raise on the same edge, so the raise is not recorded.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    localparam int SRC_N  = 32;
    localparam int LVL_W  = 16;
    localparam int TGT_W  = 4;
    localparam int ADDR_W = 3;
    localparam int MAP_W  = 4;

    localparam logic [SRC_N-1:0] FIXED_OFF   = 32'h0FA2_007F;
    localparam logic [SRC_N-1:0] VALID_MASK  = ~FIXED_OFF;
    localparam int               GLOBAL_BIT  = SRC_N - 1;
    localparam logic [LVL_W-1:0] SOFT_KEEP   = {{(LVL_W-1){1'b1}}, 1'b0};

    typedef enum logic [ADDR_W-1:0] {
        WORD_PEND    = 3'd0,
        WORD_DIS     = 3'd1,
        WORD_ENABLE  = 3'd2,
        WORD_DISABLE = 3'd3,
        WORD_TARGET  = 3'd4
    } word_e;

    // Default source-to-level table: entry j holds (j mod 15) + 1.
    function automatic logic [SRC_N*MAP_W-1:0] default_level_map();
        logic [SRC_N*MAP_W-1:0] m;
        m = '0;
        for (int j = 0; j < SRC_N; j++) begin
            m[j*MAP_W +: MAP_W] = MAP_W'((j % 15) + 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/irqr_regs.sv
module irqr_regs
    import irqr_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int TIMER_SRC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     src_i,
    input  logic [NCPU-1:0]      tmr_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [SRC_N-1:0]     wdata_i,
    output logic [SRC_N-1:0]     rdata_o,
    output logic [SRC_N-1:0]     pend_o,
    output logic [SRC_N-1:0]     dis_o,
    output logic [TGT_W-1:0]     tgt_o
);

    localparam logic [SRC_N-1:0] TIMER_ONEHOT = SRC_N'(1) << TIMER_SRC;

    logic [SRC_N-1:0] pend_q, dis_q, src_q;
    logic [SRC_N-1:0] pend_d, dis_d;
    logic [TGT_W-1:0] tgt_q, tgt_d;
    logic [NCPU-1:0]  tmr_q;
    logic [SRC_N-1:0] set_v, clr_v, strobe_v;
    logic             tmr_rise, tmr_fall;

    always_comb begin
        tmr_rise = |(tmr_i & ~tmr_q);
        tmr_fall = |(~tmr_i & tmr_q);
        strobe_v = wdata_i & VALID_MASK;
        set_v    = (src_i & ~src_q & ~dis_q) | (tmr_rise ? TIMER_ONEHOT : '0);
        clr_v    = (~src_i & src_q) | (tmr_fall ? TIMER_ONEHOT : '0);
        pend_d   = (pend_q | set_v) & ~clr_v;
        dis_d    = dis_q;
        tgt_d    = tgt_q;
        if (we_i) begin
            case (addr_i)
                WORD_ENABLE:  dis_d = dis_q & ~strobe_v;
                WORD_DISABLE: begin
                    dis_d  = dis_q | strobe_v;
                    pend_d = pend_d & ~strobe_v;
                end
                WORD_TARGET:  tgt_d = wdata_i[TGT_W-1:0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            dis_q  <= FIXED_OFF;
            tgt_q  <= '0;
            src_q  <= '0;
            tmr_q  <= '0;
        end else begin
            pend_q <= pend_d;
            dis_q  <= dis_d;
            tgt_q  <= tgt_d;
            src_q  <= src_i;
            tmr_q  <= tmr_i;
        end
    end

    always_comb begin
        case (addr_i)
            WORD_PEND:   rdata_o = pend_q & ~(SRC_N'(1) << GLOBAL_BIT);
            WORD_DIS:    rdata_o = dis_q & VALID_MASK;
            WORD_TARGET: rdata_o = {{(SRC_N-TGT_W){1'b0}}, tgt_q};
            default:     rdata_o = '0;
        endcase
    end

    assign pend_o = pend_q;
    assign dis_o  = dis_q;
    assign tgt_o  = tgt_q;

    AST_FIXED_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q & FIXED_OFF) == FIXED_OFF); // R3
    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == WORD_ENABLE) |=> (dis_q & $past(wdata_i & VALID_MASK)) == '0); // R3
    AST_DISABLE_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == WORD_DISABLE) |=> (pend_q & $past(wdata_i & VALID_MASK)) == '0); // R4
    AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == WORD_TARGET) |=> tgt_q == $past(wdata_i[TGT_W-1:0])); // R5
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_i[0] && src_q[0]) |=> !pend_q[0]); // R6

endmodule

// File: rtl/irqr_route.sv
module irqr_route
    import irqr_pkg::*;
#(
    parameter int                       NCPU      = 4,
    parameter int                       TIMER_SRC = 14,
    parameter logic [SRC_N*MAP_W-1:0]   LEVEL_MAP = default_level_map()
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_N-1:0]        pend_i,
    input  logic [SRC_N-1:0]        dis_i,
    input  logic [TGT_W-1:0]        tgt_i,
    input  logic [NCPU-1:0]         tmr_i,
    input  logic [NCPU*LVL_W-1:0]   soft_i,
    output logic [NCPU*LVL_W-1:0]   lvl_o
);

    localparam logic [LVL_W-1:0] TIMER_LVL =
        LVL_W'(1) << LEVEL_MAP[TIMER_SRC*MAP_W +: MAP_W];

    logic [LVL_W-1:0] master_vec;

    always_comb begin
        master_vec = '0;
        if (pend_i != '0 && !dis_i[GLOBAL_BIT]) begin
            for (int j = 0; j < SRC_N; j++) begin
                if (pend_i[j]) begin
                    master_vec[LEVEL_MAP[j*MAP_W +: MAP_W]] = 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        logic [LVL_W-1:0] lvl_q, lvl_d;
        logic [LVL_W-1:0] soft_g;

        assign soft_g = soft_i[g*LVL_W +: LVL_W] & SOFT_KEEP;

        always_comb begin
            lvl_d = soft_g;
            if (tgt_i == TGT_W'(g)) lvl_d = lvl_d | master_vec;
            if (tmr_i[g])           lvl_d = lvl_d | TIMER_LVL;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= '0;
            else        lvl_q <= lvl_d;
        end

        assign lvl_o[g*LVL_W +: LVL_W] = lvl_q;

        AST_LEVEL0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !lvl_q[0]); // R9
        AST_OFF_TARGET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_i != TGT_W'(g) && soft_g == '0 && !tmr_i[g]) |=> lvl_q == '0); // R8
        AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (dis_i[GLOBAL_BIT] && soft_g == '0 && !tmr_i[g]) |=> lvl_q == '0); // R8
    end

endmodule

// File: rtl/irq_master_router.sv
module irq_master_router
    import irqr_pkg::*;
#(
    parameter int                       NCPU      = 4,
    parameter int                       TIMER_SRC = 14,
    parameter logic [SRC_N*MAP_W-1:0]   LEVEL_MAP = default_level_map()
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_N-1:0]        src_lines,
    input  logic [NCPU-1:0]         timer_lines,
    input  logic [NCPU*LVL_W-1:0]   soft_levels,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [SRC_N-1:0]        bus_wdata,
    output logic [SRC_N-1:0]        bus_rdata,
    output logic [NCPU*LVL_W-1:0]   cpu_levels
);

    logic [SRC_N-1:0] pend, dis;
    logic [TGT_W-1:0] tgt;

    irqr_regs #(
        .NCPU      (NCPU),
        .TIMER_SRC (TIMER_SRC)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_lines),
        .tmr_i   (timer_lines),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .pend_o  (pend),
        .dis_o   (dis),
        .tgt_o   (tgt)
    );

    irqr_route #(
        .NCPU      (NCPU),
        .TIMER_SRC (TIMER_SRC),
        .LEVEL_MAP (LEVEL_MAP)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .dis_i  (dis),
        .tgt_i  (tgt),
        .tmr_i  (timer_lines),
        .soft_i (soft_levels),
        .lvl_o  (cpu_levels)
    );

endmodule

// File: tb/sim_irq_master_router.sv
module sim_irq_master_router;

    localparam int NCPU = 4;
    localparam int TSRC = 14;
    localparam logic [31:0] OFFBITS = 32'h0FA2_007F;
    localparam logic [31:0] VALIDB  = ~OFFBITS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lines = '0;
    logic [NCPU-1:0] timer_lines = '0;
    logic [NCPU*16-1:0] soft_levels = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCPU*16-1:0] cpu_levels;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    string phase = "R1";

    irq_master_router #(.NCPU(NCPU), .TIMER_SRC(TSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_lines(src_lines), .timer_lines(timer_lines),
        .soft_levels(soft_levels), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_levels(cpu_levels)
    );

    always #5 clk = ~clk;

    // Reference model state
    logic [31:0] m_pend, m_dis, m_srcq;
    logic [3:0]  m_tgt;
    logic [NCPU-1:0] m_tmrq;
    logic [15:0] m_lvl [NCPU];

    function automatic int lvl_of(int j);
        return (j % 15) + 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_dis = OFFBITS; m_tgt = '0; m_srcq = '0; m_tmrq = '0;
            for (int i = 0; i < NCPU; i++) m_lvl[i] = '0;
        end else begin
            logic [31:0] np, setv, clrv;
            logic trise, tfall;
            for (int i = 0; i < NCPU; i++) begin
                logic [15:0] lv;
                lv = soft_levels[i*16 +: 16] & 16'hFFFE;
                if (i == int'(m_tgt) && m_pend != 0 && !m_dis[31])
                    for (int j = 0; j < 32; j++) if (m_pend[j]) lv[lvl_of(j)] = 1'b1;
                if (timer_lines[i]) lv[lvl_of(TSRC)] = 1'b1;
                m_lvl[i] = lv;
            end
            trise = (timer_lines & ~m_tmrq) != 0;
            tfall = (~timer_lines & m_tmrq) != 0;
            setv = src_lines & ~m_srcq & ~m_dis;
            clrv = ~src_lines & m_srcq;
            if (trise) setv[TSRC] = 1'b1;
            if (tfall) clrv[TSRC] = 1'b1;
            np = (m_pend | setv) & ~clrv;
            if (bus_we) begin
                if (bus_addr == 3'd2) m_dis = m_dis & ~(bus_wdata & VALIDB);
                if (bus_addr == 3'd3) begin
                    m_dis = m_dis | (bus_wdata & VALIDB);
                    np = np & ~(bus_wdata & VALIDB);
                end
                if (bus_addr == 3'd4) m_tgt = bus_wdata[3:0];
            end
            m_pend = np;
            m_srcq = src_lines;
            m_tmrq = timer_lines;
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (bus_addr)
            3'd0: return m_pend & 32'h7FFF_FFFF;
            3'd1: return m_dis & VALIDB;
            3'd4: return {28'd0, m_tgt};
            default: return '0;
        endcase
    endfunction

    task automatic compare();
        for (int i = 0; i < NCPU; i++) begin
            n_vec++;
            if (cpu_levels[i*16 +: 16] !== m_lvl[i]) begin
                n_bad++;
                $display("FAIL %s cpu%0d levels actual=%h expected=%h", phase, i,
                         cpu_levels[i*16 +: 16], m_lvl[i]);
            end
        end
        n_vec++;
        if (bus_rdata !== exp_rdata()) begin
            n_bad++;
            $display("FAIL %s R2 read word %0d actual=%h expected=%h", phase, bus_addr,
                     bus_rdata, exp_rdata());
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_addr = a;
        #1;
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        phase = "R1";
        compare();                       // R1 reset state
        rst_n = 1'b1;
        tick();
        rd(3'd1); rd(3'd4); rd(3'd0);    // R1 R2

        phase = "R6";                    // R6 raise then drop bit 8 -> level 9 on cpu0
        src_lines[8] = 1'b1; tick(); tick();
        src_lines[8] = 1'b0; tick(); tick();

        phase = "R5";                    // R5 target cpu2, bit 10 -> level 11
        wr(3'd4, 32'hFFFF_FFF2); rd(3'd4);
        src_lines[10] = 1'b1; tick(); tick();

        phase = "R2";                    // R2 bit 31 pending reads back as 0
        src_lines[31] = 1'b1; tick(); tick();
        rd(3'd0); rd(3'd1); rd(3'd5); rd(3'd7);
        src_lines[31] = 1'b0; tick();

        phase = "R4";                    // R4 disable everything, pending dropped
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd1); rd(3'd0);
        src_lines[9] = 1'b1; tick(); tick(); rd(3'd0);
        phase = "R3";                    // R3 enable, held line gives no new pending
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd1); tick();
        src_lines[9] = 1'b0; tick();
        src_lines[9] = 1'b1; tick(); tick();

        phase = "R4";                    // R4 raise and disable strobe on one edge
        src_lines[12] = 1'b1;
        wr(3'd3, 32'h0000_1000); rd(3'd0); tick();
        wr(3'd2, 32'h0000_1000);

        phase = "R7";                    // R7 timer on cpu1, master bit 14 to cpu2
        timer_lines[1] = 1'b1; tick(); tick(); rd(3'd0);
        timer_lines[1] = 1'b0; tick(); tick();
        timer_lines[3] = 1'b1;           // R7 timer raise versus disable of bit 14
        wr(3'd3, 32'h0000_4000); rd(3'd0); tick();
        timer_lines[3] = 1'b0; tick();
        wr(3'd2, 32'h0000_4000);

        phase = "R8";                    // R8 out-of-range target, then global off
        wr(3'd4, 32'd9); tick(); tick();
        wr(3'd4, 32'd0); tick();
        wr(3'd3, 32'h8000_0000); tick(); rd(3'd1);
        wr(3'd2, 32'h8000_0000); tick();

        phase = "R9";                    // R9 soft levels with bit 0 set
        soft_levels = 64'h8001_00FF_0003_FFFF; tick(); tick();
        soft_levels = '0; tick();

        phase = "R10";                   // R10 random traffic, per-cycle compare
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            src_lines = src_lines ^ ($urandom & $urandom & $urandom);
            if (r[3:0] == 4'd0) timer_lines = timer_lines ^ NCPU'(r[7:4]);
            if (r[9:8] == 2'd0) soft_levels = {$urandom, $urandom};
            bus_we = (r[12:10] == 3'd0);
            bus_addr = r[15:13];
            bus_wdata = (r[16]) ? $urandom : ($urandom & $urandom);
            if (bus_addr == 3'd4) bus_wdata = {28'd0, 2'b00, r[18:17]} | (r[19] ? 32'd8 : 32'd0);
            tick();
        end
        bus_we = 1'b0;
        tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule